// File: doc/BRIEF.md
# Program Counter and Return Stack Sequencer

This block owns the 10-bit instruction address of a small controller core and the return-address stack that backs its subroutine calls. Each clock the decoder presents one operation code: hold, step, full jump, low-byte jump, call or return. The block computes the next address and, for calls and returns, addresses the stack slot in data memory.

The return stack has no storage of its own. It lives in the four highest register pairs of the shared data memory and is selected by a 2-bit pointer. The block exposes a slot index, a write strobe and write data, and it takes the slot's read data back. A call saves the address one past the current instruction. A return resumes two past the saved value, which skips the word that follows the call. A separate depth counter allows at most four nested calls. Pushing a fifth frame, or popping an empty stack, is treated as a CPU fault. The fault clears the sequencer and pulses a reset request to the rest of the core.

Top module: `prog_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` and `ptr` become 0 and `rst_req` becomes 0; `stk_we` is 0 whenever `op` is not a call.
- R2: Operation code 1 (step) makes `pc` one higher after the edge, wrapping from 3FFh to 000h.
- R3: Operation code 0 (hold) and the unused codes 6 and 7 leave `pc` and `ptr` unchanged, whatever `tgt` holds.
- R4: Operation code 2 (full jump) loads all ten bits of `tgt` into `pc`.
- R5: Operation code 3 (low jump) loads `tgt[7:0]` into `pc[7:0]` and keeps `pc[9:8]`.
- R6: Operation code 4 (call), when allowed, raises `stk_we` in the same cycle with `stk_wdata` = `pc`+1 and `stk_reg` = 15 − `ptr`. After the edge, `pc` = `tgt` and `ptr` is one higher (mod 4).
- R7: Operation code 5 (return), when allowed, drives `stk_reg` = 15 − ((`ptr`−1) mod 4) in that cycle. After the edge, `pc` = `stk_rdata`+2 (mod 1024) and `ptr` is one lower (mod 4).
- R8: Pointer values 0, 1, 2 and 3 select register pairs 15, 14, 13 and 12 respectively.
- R9: A call made while four frames are outstanding performs no stack write. After the edge, `pc` = 0, `ptr` = 0 and `rst_req` is high for that one cycle.
- R10: A return made with no frame outstanding does the same: `pc` = 0, `ptr` = 0 and a single-cycle `rst_req`. Stale data left in the stack slots does not prevent this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on or all-clear) |
| op | input | 3 | Operation code from the decoder for this cycle |
| tgt | input | 10 | Jump or call destination |
| stk_rdata | input | 10 | Contents of the register pair named by `stk_reg` |
| pc | output | 10 | Current instruction address |
| ptr | output | 2 | Return-stack pointer |
| stk_reg | output | 4 | Register-pair index of the active stack slot |
| stk_we | output | 1 | Write strobe for the stack slot |
| stk_wdata | output | 10 | Return address to be saved |
| rst_req | output | 1 | Internal reset request after a stack fault |

## Verification
A corrupted depth count cannot be seen until it changes whether a push or a pop faults. It therefore shows up either as a missing `rst_req` on the fifth nested call or on an empty return, or as a false `rst_req` inside a legal four-deep nest. The bench drives both edges of the depth window. A pointer or slot-mapping error appears in the same cycle on `stk_reg`. An error in the link arithmetic appears on `stk_wdata` in the call cycle, and on `pc` one edge after the matching return. The wrap case, a saved 3FFh that resumes at 001h, is exercised on purpose.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_STEP  = 3'd1,
        OP_JFULL = 3'd2,
        OP_JLOW  = 3'd3,
        OP_CALL  = 3'd4,
        OP_RET   = 3'd5
    } seq_op_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic fault;
    } stk_ctl_t;

    function automatic logic is_call(input logic [2:0] code);
        return code == OP_CALL;
    endfunction

    function automatic logic is_ret(input logic [2:0] code);
        return code == OP_RET;
    endfunction

endpackage

// File: rtl/pcs_depth.sv
module pcs_depth #(
    parameter int DEPTH = 4,
    localparam int DW = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic push_req,
    input  logic pop_req,
    output logic fault
);
    localparam logic [DW-1:0] FULL = DW'(DEPTH);

    logic [DW-1:0] depth_q;

    always_comb begin
        fault = (push_req && depth_q == FULL) || (pop_req && depth_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || fault) begin
            depth_q <= '0;
        end else if (push_req) begin
            depth_q <= depth_q + 1'b1;
        end else if (pop_req) begin
            depth_q <= depth_q - 1'b1;
        end
    end

    // R9
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        depth_q <= FULL);

    // R10
    empty_pop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_req && depth_q == '0) |=> depth_q == '0);

endmodule

// File: rtl/pcs_ptr.sv
module pcs_ptr #(
    parameter int DEPTH   = 4,
    parameter int REG_W   = 4,
    parameter int TOP_REG = 15,
    localparam int SP_W   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic             sel_pop,
    output logic [SP_W-1:0]  ptr,
    output logic [REG_W-1:0] slot_reg
);
    localparam logic [REG_W-1:0] TOP_V = REG_W'(TOP_REG);

    logic [SP_W-1:0] ptr_q;
    logic [SP_W-1:0] sel;

    always_comb begin
        sel      = sel_pop ? ptr_q - 1'b1 : ptr_q;
        slot_reg = TOP_V - REG_W'(sel);
        ptr      = ptr_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ptr_q <= '0;
        end else if (push) begin
            ptr_q <= ptr_q + 1'b1;
        end else if (pop) begin
            ptr_q <= ptr_q - 1'b1;
        end
    end

    // R7
    pop_moves_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !clr) |=> ptr_q == $past(ptr_q) - 1'b1);

    // R8
    slot_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        slot_reg > TOP_V - REG_W'(DEPTH));

endmodule

// File: rtl/pcs_next.sv
module pcs_next
    import pcs_pkg::*;
#(
    parameter int PC_W     = 10,
    parameter int LOW_W    = 8,
    parameter int CALL_ADV = 1,
    parameter int RET_ADV  = 2
) (
    input  logic [2:0]      op,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] tgt,
    input  logic [PC_W-1:0] rdata,
    output logic [PC_W-1:0] nxt,
    output logic [PC_W-1:0] link
);
    always_comb begin
        link = pc + PC_W'(CALL_ADV);
        case (seq_op_e'(op))
            OP_STEP:  nxt = pc + 1'b1;
            OP_JFULL: nxt = tgt;
            OP_JLOW:  nxt = {pc[PC_W-1:LOW_W], tgt[LOW_W-1:0]};
            OP_CALL:  nxt = tgt;
            OP_RET:   nxt = rdata + PC_W'(RET_ADV);
            default:  nxt = pc;
        endcase
    end

endmodule

// File: rtl/prog_seq.sv
module prog_seq
    import pcs_pkg::*;
#(
    parameter int PC_W    = 10,
    parameter int LOW_W   = 8,
    parameter int DEPTH   = 4,
    parameter int REG_W   = 4,
    parameter int TOP_REG = 15,
    localparam int SP_W   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op,
    input  logic [PC_W-1:0]  tgt,
    input  logic [PC_W-1:0]  stk_rdata,
    output logic [PC_W-1:0]  pc,
    output logic [SP_W-1:0]  ptr,
    output logic [REG_W-1:0] stk_reg,
    output logic             stk_we,
    output logic [PC_W-1:0]  stk_wdata,
    output logic             rst_req
);
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_nxt;
    logic [PC_W-1:0] link;
    logic            rq_q;
    stk_ctl_t        ctl;

    pcs_depth #(.DEPTH(DEPTH)) u_depth (
        .clk      (clk),
        .rst      (rst),
        .push_req (is_call(op)),
        .pop_req  (is_ret(op)),
        .fault    (ctl.fault)
    );

    always_comb begin
        ctl.push = is_call(op) && !ctl.fault;
        ctl.pop  = is_ret(op) && !ctl.fault;
    end

    pcs_ptr #(.DEPTH(DEPTH), .REG_W(REG_W), .TOP_REG(TOP_REG)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .clr      (ctl.fault),
        .push     (ctl.push),
        .pop      (ctl.pop),
        .sel_pop  (is_ret(op)),
        .ptr      (ptr),
        .slot_reg (stk_reg)
    );

    pcs_next #(.PC_W(PC_W), .LOW_W(LOW_W)) u_next (
        .op    (op),
        .pc    (pc_q),
        .tgt   (tgt),
        .rdata (stk_rdata),
        .nxt   (pc_nxt),
        .link  (link)
    );

    always_ff @(posedge clk) begin
        if (rst || ctl.fault) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rq_q <= 1'b0;
        end else begin
            rq_q <= ctl.fault;
        end
    end

    assign pc        = pc_q;
    assign stk_we    = ctl.push;
    assign stk_wdata = link;
    assign rst_req   = rq_q;

    // R9
    fault_clears_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (pc == '0 && ptr == '0));

    // R9
    rq_single_chk: assert property (@(posedge clk) disable iff (rst)
        !(is_call(op) || is_ret(op)) |=> !rst_req);

    // R6
    push_only_on_call_chk: assert property (@(posedge clk) disable iff (rst)
        stk_we |-> is_call(op));

    // R6
    push_moves_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        stk_we |=> (ptr == $past(ptr) + 1'b1 && pc == $past(tgt)));

    // R2
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP) |=> pc == $past(pc) + 1'b1);

endmodule

// File: tb/tb_prog_seq.sv
module tb_prog_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op  = 3'd0;
    logic [9:0] tgt = '0;
    logic [9:0] stk_rdata;
    logic [9:0] pc;
    logic [1:0] ptr;
    logic [3:0] stk_reg;
    logic       stk_we;
    logic [9:0] stk_wdata;
    logic       rst_req;

    int checks = 0;
    int fails  = 0;

    logic [9:0] ram [16];

    always #2.5 clk = ~clk;

    always @(posedge clk) if (stk_we) ram[stk_reg] <= stk_wdata;
    assign stk_rdata = ram[stk_reg];

    prog_seq dut (
        .clk(clk), .rst(rst), .op(op), .tgt(tgt), .stk_rdata(stk_rdata),
        .pc(pc), .ptr(ptr), .stk_reg(stk_reg), .stk_we(stk_we),
        .stk_wdata(stk_wdata), .rst_req(rst_req)
    );

    typedef struct packed {
        logic [2:0] op;
        logic [9:0] tgt;
        logic       we;
        logic [9:0] wd;
        logic [3:0] rg;
        logic [9:0] pc;
        logic [1:0] ptr;
    } vec_t;

    localparam vec_t [0:13] VEC = '{
        '{3'd1, 10'h000, 1'b0, 10'h000, 4'hF, 10'h001, 2'd0},
        '{3'd1, 10'h000, 1'b0, 10'h000, 4'hF, 10'h002, 2'd0},
        '{3'd2, 10'h3FE, 1'b0, 10'h000, 4'hF, 10'h3FE, 2'd0},
        '{3'd1, 10'h000, 1'b0, 10'h000, 4'hF, 10'h3FF, 2'd0},
        '{3'd1, 10'h000, 1'b0, 10'h000, 4'hF, 10'h000, 2'd0},
        '{3'd2, 10'h2C5, 1'b0, 10'h000, 4'hF, 10'h2C5, 2'd0},
        '{3'd3, 10'h31A, 1'b0, 10'h000, 4'hF, 10'h21A, 2'd0},
        '{3'd0, 10'h155, 1'b0, 10'h000, 4'hF, 10'h21A, 2'd0},
        '{3'd7, 10'h0AA, 1'b0, 10'h000, 4'hF, 10'h21A, 2'd0},
        '{3'd4, 10'h100, 1'b1, 10'h21B, 4'hF, 10'h100, 2'd1},
        '{3'd4, 10'h200, 1'b1, 10'h101, 4'hE, 10'h200, 2'd2},
        '{3'd1, 10'h000, 1'b0, 10'h000, 4'hD, 10'h201, 2'd2},
        '{3'd5, 10'h000, 1'b0, 10'h000, 4'hE, 10'h103, 2'd1},
        '{3'd5, 10'h000, 1'b0, 10'h000, 4'hF, 10'h21D, 2'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // entered at a falling edge; returns at the next falling edge
    task automatic do_op(input logic [2:0] o, input logic [9:0] t,
                         input logic we, input logic [9:0] wd, input logic [3:0] rg,
                         input logic [9:0] epc, input logic [1:0] eptr,
                         input logic erq, input string req);
        op  = o;
        tgt = t;
        #1;
        chk({req, " stk_we"}, int'(stk_we), int'(we));
        if (we) chk({req, " stk_wdata"}, int'(stk_wdata), int'(wd));
        chk({req, " stk_reg"}, int'(stk_reg), int'(rg));
        @(negedge clk);
        chk({req, " pc"}, int'(pc), int'(epc));
        chk({req, " ptr"}, int'(ptr), int'(eptr));
        chk({req, " rst_req"}, int'(rst_req), int'(erq));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        op  = 3'd0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 pc", int'(pc), 0);
        chk("R1 ptr", int'(ptr), 0);
        chk("R1 rst_req", int'(rst_req), 0);
        chk("R1 stk_we", int'(stk_we), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R2 R3 R4 R5 R6 R7 R8: vector walk
        for (int i = 0; i < 14; i++) begin
            do_op(VEC[i].op, VEC[i].tgt, VEC[i].we, VEC[i].wd, VEC[i].rg,
                  VEC[i].pc, VEC[i].ptr, 1'b0, $sformatf("R2-vec%0d", i));
        end

        // R8 R9: four legal nested calls, then an overflowing fifth
        do_reset();
        do_op(3'd4, 10'h010, 1'b1, 10'h001, 4'hF, 10'h010, 2'd1, 1'b0, "R8 call1");
        do_op(3'd4, 10'h020, 1'b1, 10'h011, 4'hE, 10'h020, 2'd2, 1'b0, "R8 call2");
        do_op(3'd4, 10'h030, 1'b1, 10'h021, 4'hD, 10'h030, 2'd3, 1'b0, "R8 call3");
        do_op(3'd4, 10'h040, 1'b1, 10'h031, 4'hC, 10'h040, 2'd0, 1'b0, "R8 call4");
        do_op(3'd4, 10'h050, 1'b0, 10'h000, 4'hF, 10'h000, 2'd0, 1'b1, "R9 overflow");
        chk("R9 slot F kept", int'(ram[15]), 10'h001);
        do_op(3'd0, 10'h000, 1'b0, 10'h000, 4'hF, 10'h000, 2'd0, 1'b0, "R9 pulse ends");

        // R10: return on an empty stack, stale slot data present
        do_op(3'd5, 10'h000, 1'b0, 10'h000, 4'hC, 10'h000, 2'd0, 1'b1, "R10 underflow");
        do_op(3'd0, 10'h000, 1'b0, 10'h000, 4'hF, 10'h000, 2'd0, 1'b0, "R10 pulse ends");

        // R7: saved 3FF resumes at 001
        do_op(3'd2, 10'h3FE, 1'b0, 10'h000, 4'hF, 10'h3FE, 2'd0, 1'b0, "R4 jump");
        do_op(3'd4, 10'h050, 1'b1, 10'h3FF, 4'hF, 10'h050, 2'd1, 1'b0, "R6 link wrap");
        do_op(3'd5, 10'h000, 1'b0, 10'h000, 4'hF, 10'h001, 2'd0, 1'b0, "R7 resume wrap");

        // R1: reset in mid-run
        do_op(3'd2, 10'h123, 1'b0, 10'h000, 4'hF, 10'h123, 2'd0, 1'b0, "R4 jump2");
        do_op(3'd4, 10'h200, 1'b1, 10'h124, 4'hF, 10'h200, 2'd1, 1'b0, "R6 call");
        do_reset();

        summary();
    end
endmodule